// File: doc/BRIEF.md
# Erasable One-Time-Writable Byte Memory Controller

This block models the control logic of a byte-wide memory whose bits can only be cleared by writing and only set again by a bulk erase. Two digital flags stand in for the electrical conditions. One says the programming supply is raised. The other says the identity-select address pin sits at its high-voltage level. Together with an active-low chip enable and an active-low output enable, these flags select one of seven operating modes. In each mode the block either drives the stored byte, returns an identifier byte, accepts a byte to program, or leaves the data bus released.

The data bus is split into an input, an output and an output-enable, so that no tristate logic sits on chip. A write takes effect when the chip enable rises at the end of a low pulse in programming mode. The new byte is merged with the old one by AND. The array depth is a parameter, and the address is decoded on its low bits. A synchronous erase input sets every bit to 1, and so does reset.

Top module: `eprom_ctl`

## Requirements
- R1: With `vpp_hi`=0, `ce_n`=0 and `oe_n`=0 (read), `dq_oe`=1 and `dq_out` shows the byte stored at the addressed location, within the same cycle.
- R2: With `vpp_hi`=0, either `ce_n`=1 (standby, any `oe_n`) or `ce_n`=0 with `oe_n`=1 (output disabled) gives `dq_oe`=0.
- R3: With `vpp_hi`=1, `ce_n`=0 and `oe_n`=1 (program), `dq_oe`=0. A write happens at the first clock edge where `ce_n` is seen high after being low, provided `vpp_hi`=1 and `oe_n`=1 at that edge. It uses the `addr` and `dq_in` present at that edge.
- R4: A write stores the old byte AND `dq_in`, so bits only go from 1 to 0; writing one location twice leaves the AND of both values.
- R5: With `vpp_hi`=1, `ce_n`=1 and `oe_n`=0 (verify), `dq_oe`=1 and `dq_out` shows the stored byte, whatever `id_hv` is.
- R6: With `vpp_hi`=1 and `ce_n`=`oe_n`=1 (inhibit), `dq_oe`=0. No location changes unless the rising-enable condition of R3 holds.
- R7: With `vpp_hi`=1, `ce_n`=0 and `oe_n`=0 (undefined combination), `dq_oe`=0. A later rise of `ce_n` while `oe_n`=0 writes nothing.
- R8: In read mode with `id_hv`=1 and `addr[18:1]`=0, `dq_out` is 0x97 when `addr[0]`=0 and 0x50 when `addr[0]`=1.
- R9: In read mode with `id_hv`=1 and any of `addr[18:1]` nonzero, `dq_out` is 0xFF.
- R10: `erase`=1 at a clock edge sets every location to 0xFF from the next cycle. Reset does the same.
- R11: Only the low log2(DEPTH) address bits select a location (default DEPTH 256), so addresses that differ only above them alias to the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; blanks the array |
| erase | input | 1 | Bulk erase to all ones |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identity-select pin at high voltage |
| ce_n | input | 1 | Active-low chip enable / program strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | 19 | Byte address |
| dq_in | input | 8 | Data bus, inbound half |
| dq_out | output | 8 | Data bus, outbound half |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
Mode decode, bus enable, signature substitution and array reads are combinational, so those results appear in the cycle the pins are applied. The bench changes pins on the falling clock edge and samples them 1 ns after the next rising edge. A write lands at the rising edge on which `ce_n` is first seen high. The vector that raises `ce_n` is therefore itself an inhibit vector, and the following verify vector is the first to see the new byte. Erase and reset take one edge, and the bench reads back only after that edge has passed.

// File: rtl/eprom_ctl.sv
module eprom_ctl #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter logic [DATA_W-1:0] MFG_ID = 8'h97,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int IDX_W = $clog2(DEPTH);

  typedef enum logic [2:0] {
    M_STBY, M_ODIS, M_READ, M_PROG, M_INH, M_VER, M_BAD
  } mode_t;

  mode_t             mode;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] sig_byte;
  logic              sig_ok;
  logic              ce_q;
  logic              wr_fire;

  assign idx     = addr[IDX_W-1:0];
  assign rd_word = mem[idx];

  always_comb begin
    case ({vpp_hi, ce_n, oe_n})
      3'b000:  mode = M_READ;
      3'b001:  mode = M_ODIS;
      3'b010,
      3'b011:  mode = M_STBY;
      3'b101:  mode = M_PROG;
      3'b111:  mode = M_INH;
      3'b110:  mode = M_VER;
      default: mode = M_BAD;
    endcase
  end

  assign sig_ok   = (addr[ADDR_W-1:1] == '0);
  assign sig_byte = !sig_ok ? '1 : (addr[0] ? DEV_ID : MFG_ID);

  assign dq_oe  = (mode == M_READ) || (mode == M_VER);
  assign dq_out = !dq_oe ? '0
                : ((mode == M_READ) && id_hv) ? sig_byte
                : rd_word;

  assign wr_fire = !ce_q && ce_n && vpp_hi && oe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q <= 1'b1;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      ce_q <= ce_n;
      if (erase) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (wr_fire) begin
        mem[idx] <= rd_word & dq_in;
      end
    end
  end

  AST_QUIET_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_hi && ce_n) |-> !dq_oe); // R2

  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !erase) |=> (idx != $past(idx)) || ((rd_word & ~$past(rd_word)) == '0)); // R4

  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && ce_n && !erase) |=> (idx != $past(idx)) || $stable(rd_word)); // R6

  AST_ERASE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (rd_word == '1)); // R10

  AST_SIG_MFG: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_hi && !ce_n && !oe_n && id_hv && addr == '0) |-> (dq_oe && dq_out == MFG_ID)); // R8

  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && !ce_n && !oe_n) |-> !dq_oe); // R7
endmodule

// File: tb/eprom_ctl_tb.sv
`timescale 1ns/1ps
module eprom_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        erase = 1'b0;
  logic        vpp_hi = 1'b0;
  logic        id_hv = 1'b0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  eprom_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .erase(erase), .vpp_hi(vpp_hi), .id_hv(id_hv),
    .ce_n(ce_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // {req[3:0], vpp, id, ce_n, oe_n, addr[18:0], din[7:0], exp_oe, exp_dq[7:0]}
  localparam int NV = 22;
  localparam logic [43:0] VEC [NV] = '{
    {4'd2,  4'b0010, 19'h00005, 8'h00, 1'b0, 8'h00}, // R2 standby
    {4'd1,  4'b0000, 19'h00005, 8'h00, 1'b1, 8'hFF}, // R1 blank read
    {4'd2,  4'b0001, 19'h00005, 8'h00, 1'b0, 8'h00}, // R2 output disable
    {4'd3,  4'b1001, 19'h00005, 8'hA5, 1'b0, 8'h00}, // R3 program pulse low
    {4'd6,  4'b1011, 19'h00005, 8'hA5, 1'b0, 8'h00}, // R6 inhibit, write edge
    {4'd5,  4'b1010, 19'h00005, 8'h00, 1'b1, 8'hA5}, // R5 verify
    {4'd3,  4'b1001, 19'h00005, 8'h3C, 1'b0, 8'h00}, // R3 second pulse
    {4'd6,  4'b1011, 19'h00005, 8'h3C, 1'b0, 8'h00}, // R6
    {4'd4,  4'b1010, 19'h00005, 8'h00, 1'b1, 8'h24}, // R4 AND merge
    {4'd1,  4'b0000, 19'h00005, 8'h00, 1'b1, 8'h24}, // R1
    {4'd1,  4'b0000, 19'h00006, 8'h00, 1'b1, 8'hFF}, // R1 neighbour
    {4'd8,  4'b0100, 19'h00000, 8'h00, 1'b1, 8'h97}, // R8 mfg id
    {4'd8,  4'b0100, 19'h00001, 8'h00, 1'b1, 8'h50}, // R8 dev id
    {4'd9,  4'b0100, 19'h00002, 8'h00, 1'b1, 8'hFF}, // R9 bit1 set
    {4'd9,  4'b0100, 19'h40000, 8'h00, 1'b1, 8'hFF}, // R9 top bit set
    {4'd5,  4'b1110, 19'h00005, 8'h00, 1'b1, 8'h24}, // R5 verify ignores id
    {4'd11, 4'b0000, 19'h00105, 8'h00, 1'b1, 8'h24}, // R11 alias
    {4'd7,  4'b1000, 19'h00005, 8'h00, 1'b0, 8'h00}, // R7 undefined
    {4'd7,  4'b1010, 19'h00005, 8'h00, 1'b1, 8'h24}, // R7 rise with oe low
    {4'd3,  4'b1001, 19'h000FF, 8'h00, 1'b0, 8'h00}, // R3 top location
    {4'd6,  4'b1011, 19'h000FF, 8'h00, 1'b0, 8'h00}, // R6
    {4'd1,  4'b0000, 19'h000FF, 8'h00, 1'b1, 8'h00}  // R1
  };

  task automatic check(input int req, input logic eoe, input logic [7:0] edq);
    applied++;
    if (dq_oe !== eoe || (eoe && dq_out !== edq)) begin
      bad++;
      $display("FAIL R%0d: oe=%b dq=%h expected oe=%b dq=%h", req, dq_oe, dq_out, eoe, edq);
    end
  endtask

  task automatic drive(input logic [3:0] pins, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    {vpp_hi, id_hv, ce_n, oe_n} = pins;
    addr = a;
    dq_in = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    drive(4'b0000, 19'h00033, 8'h00);
    check(10, 1'b1, 8'hFF); // R10 reset leaves blank

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][39:36], VEC[i][35:17], VEC[i][16:9]);
      check(int'(VEC[i][43:40]), VEC[i][8], VEC[i][7:0]);
    end

    // R3: supply dropped before enable rises -> no write
    drive(4'b1001, 19'h00010, 8'h00);
    drive(4'b0011, 19'h00010, 8'h00);
    drive(4'b0000, 19'h00010, 8'h00);
    check(3, 1'b1, 8'hFF);

    // R3: address changed while low, write uses address at rising edge
    drive(4'b1001, 19'h00020, 8'h0F);
    @(negedge clk); addr = 19'h00021; dq_in = 8'hF0; ce_n = 1'b1;
    @(posedge clk); #1;
    drive(4'b0000, 19'h00021, 8'h00);
    check(3, 1'b1, 8'hF0);
    drive(4'b0000, 19'h00020, 8'h00);
    check(3, 1'b1, 8'hFF);

    // R10: erase restores blank
    @(negedge clk); erase = 1'b1;
    @(negedge clk); erase = 1'b0;
    drive(4'b0000, 19'h00005, 8'h00);
    check(10, 1'b1, 8'hFF);
    drive(4'b0000, 19'h00021, 8'h00);
    check(10, 1'b1, 8'hFF);

    // R10: reset also blanks
    drive(4'b1001, 19'h00044, 8'h12);
    drive(4'b1011, 19'h00044, 8'h12);
    drive(4'b0000, 19'h00044, 8'h00);
    check(4, 1'b1, 8'h12);
    @(negedge clk); rst_n = 1'b0; ce_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    drive(4'b0000, 19'h00044, 8'h00);
    check(10, 1'b1, 8'hFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      applied++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule